// File: doc/BRIEF.md
# Zero-Operand Stack Processor Core

This block is a small word-addressed processor whose instructions carry no operand fields. Every instruction word is read from memory and classified by its value. A value from 0 to 15 selects one of sixteen primitive operations. Any larger value is a call to the subroutine at that address. The core has five registers: an accumulator A, a scratch and address register Q, a data-stack pointer S, a return-stack pointer R and a program counter P. Both stacks live in the same memory as the program and grow downward from separate base addresses. S and R always point at the current top cell.

There is no literal opcode. A literal is written as a call to a short literal routine, followed by the value itself. The routine reads its own return address, fetches the word stored there, pushes that word onto the data stack, and writes back a return address that skips the literal. A build-time option adds a comparator on one configured subroutine address. On a match, the core performs the same work directly: A gets the literal, the literal is pushed, and Q and P both become the address after the literal. The return stack is not touched.

All memory traffic goes through one single-port request channel with valid/ready handshaking. A request is the address, the write enable and the write data, and it is presented with `mem_valid`. The core keeps the whole request steady until it sees `mem_ready`. A read is complete when it is accepted, and its data must appear on `mem_rdata` exactly one cycle later. The core always takes the read data, so the return path needs no handshake. Every instruction costs one fetch plus at most one data access.

Top module: `zop_core`

## Requirements
- R1: After reset, A and Q are zero, S and R hold their base values, and the first bus request is a read of address 0.
- R2: A request that is not accepted keeps its address, write enable and write data unchanged until `mem_ready` is high. A read's data is taken from `mem_rdata` in the cycle after acceptance, so results do not depend on the stall pattern.
- R3: A word of value 16 or more is a call. R is decremented first, P+1 is written to the new R cell, and execution continues at the word's value.
- R4: Opcode 0 (return) loads P from the cell at R and increments R.
- R5: Opcodes 8, 9 and 10 combine A with the cell at S by add (modulo the word width), XOR and AND respectively. The result goes to A and S is incremented.
- R6: Opcode 1 loads A from the cell at S, and opcode 2 loads Q from it; both then increment S. Opcode 6 decrements S and writes A to the new top. Opcode 3 writes A to the cell addressed by Q.
- R7: Opcode 4 loads Q from the cell at R. Opcode 5 loads A from the cell at Q and then adds one to Q. Opcode 7 writes Q to the cell at R. Together with return, these let a routine at address 16 (words 4, 5, 6, 7, 0) push the word that follows a call to it and resume after that word.
- R8: Opcode 12 skips the next word when A is zero and otherwise continues with the next word.
- R9: Opcode 13 loads P from Q, and opcode 14 copies A into Q.
- R10: Opcode 11 increments S, dropping the top cell. Opcode 15 changes no register except P.
- R11: Each primitive or call makes exactly one instruction fetch. Opcodes 11 to 15 make no data access. Every other opcode, and every call, makes exactly one data access.
- R12: With the shortcut enabled, a word equal to the configured literal address makes three bus accesses and no return-stack traffic. It leaves memory with the same results as the software routine and needs fewer cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Word address of the request |
| mem_wdata | output | W | Data for a write request |
| mem_rdata | input | W | Read data, valid one cycle after a read is accepted |

## Verification
The assertions assume two things about the environment. First, the program keeps both stacks balanced, so neither pointer ever climbs past its base. Second, the memory returns read data exactly one cycle after acceptance. Every bench program pushes each cell before popping it, and the bench memory model answers with that fixed latency. Back-pressure is driven by a pseudo-random ready pattern on half of the runs, and the expected results are required to be identical with and without stalls.

// File: rtl/zop_pkg.sv
package zop_pkg;

  typedef enum logic [3:0] {
    OP_RET    = 4'd0,
    OP_LDS_A  = 4'd1,
    OP_LDS_Q  = 4'd2,
    OP_ST_AQ  = 4'd3,
    OP_LDR_Q  = 4'd4,
    OP_LDQ_A  = 4'd5,
    OP_PUSH   = 4'd6,
    OP_STQ_R  = 4'd7,
    OP_ADD    = 4'd8,
    OP_XOR    = 4'd9,
    OP_AND    = 4'd10,
    OP_DROP   = 4'd11,
    OP_SKZ    = 4'd12,
    OP_JMPQ   = 4'd13,
    OP_MOVQ   = 4'd14,
    OP_NOP    = 4'd15
  } prim_e;

  typedef enum logic [1:0] {ST_FETCH, ST_DECODE, ST_MEM, ST_WB} state_e;

  typedef enum logic [1:0] {K_PRIM, K_CALL, K_HWLIT} kind_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_XOR, ALU_AND, ALU_PASS} alu_e;

endpackage

// File: rtl/zop_decode.sv
module zop_decode
  import zop_pkg::*;
#(
  parameter int             W        = 16,
  parameter bit             HW_LIT   = 1'b0,
  parameter logic [W-1:0]   LIT_ADDR = 16'h0010
) (
  input  logic [W-1:0] word,
  output kind_e        kind,
  output prim_e        op,
  output logic         uses_mem,
  output logic         writes_mem
);

  logic is_call;
  logic lit_hit;

  // any bit above the low nibble makes the word a call target
  assign is_call = |word[W-1:4];

  generate
    if (HW_LIT) begin : g_hw_lit
      assign lit_hit = (word == LIT_ADDR);
    end else begin : g_sw_lit
      assign lit_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    op   = prim_e'(word[3:0]);
    kind = K_PRIM;
    if (is_call) kind = lit_hit ? K_HWLIT : K_CALL;
    case (kind)
      K_CALL: begin
        uses_mem   = 1'b1;
        writes_mem = 1'b1;
      end
      K_HWLIT: begin
        uses_mem   = 1'b1;
        writes_mem = 1'b0;
      end
      default: begin
        uses_mem   = !(op inside {OP_DROP, OP_SKZ, OP_JMPQ, OP_MOVQ, OP_NOP});
        writes_mem = op inside {OP_ST_AQ, OP_PUSH, OP_STQ_R};
      end
    endcase
  end

endmodule

// File: rtl/zop_alu.sv
module zop_alu
  import zop_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_e         fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_XOR: y = a ^ b;
      ALU_AND: y = a & b;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/zop_core.sv
module zop_core
  import zop_pkg::*;
#(
  parameter int           W        = 16,
  parameter logic [W-1:0] DS_BASE  = 16'hE000,
  parameter logic [W-1:0] RS_BASE  = 16'hF000,
  parameter bit           HW_LIT   = 1'b0,
  parameter logic [W-1:0] LIT_ADDR = 16'h0010
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         mem_valid,
  input  logic         mem_ready,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  state_e       state;
  logic [W-1:0] pc, acc, qr, sp, rp, ir;
  logic         lit_push;

  logic [W-1:0] cur_word;
  kind_e        kind;
  prim_e        op;
  logic         uses_mem, dec_we, wr_now;
  alu_e         alu_fn;
  logic [W-1:0] alu_y;
  logic [W-1:0] pc_inc, sp_dn, rp_dn;
  logic [W-1:0] data_addr, data_wdata;

  // the fetched word is decoded straight off the read bus, later from ir
  assign cur_word = (state == ST_DECODE) ? mem_rdata : ir;

  zop_decode #(.W(W), .HW_LIT(HW_LIT), .LIT_ADDR(LIT_ADDR)) u_decode (
    .word       (cur_word),
    .kind       (kind),
    .op         (op),
    .uses_mem   (uses_mem),
    .writes_mem (dec_we)
  );

  always_comb begin
    case (op)
      OP_XOR:  alu_fn = ALU_XOR;
      OP_AND:  alu_fn = ALU_AND;
      default: alu_fn = ALU_ADD;
    endcase
  end

  zop_alu #(.W(W)) u_alu (
    .fn (alu_fn),
    .a  (acc),
    .b  (mem_rdata),
    .y  (alu_y)
  );

  assign pc_inc = pc + ONE;
  assign sp_dn  = sp - ONE;
  assign rp_dn  = rp - ONE;
  assign wr_now = (kind == K_HWLIT) ? lit_push : dec_we;

  always_comb begin
    data_addr  = sp;
    data_wdata = acc;
    if (kind == K_CALL) begin
      data_addr  = rp_dn;
      data_wdata = pc_inc;
    end else if (kind == K_HWLIT) begin
      data_addr  = lit_push ? sp_dn : pc_inc;
    end else begin
      case (op)
        OP_RET, OP_LDR_Q:  data_addr = rp;
        OP_ST_AQ, OP_LDQ_A: data_addr = qr;
        OP_PUSH:           data_addr = sp_dn;
        OP_STQ_R: begin
          data_addr  = rp;
          data_wdata = qr;
        end
        default:           data_addr = sp;
      endcase
    end
  end

  assign mem_valid = (state == ST_FETCH) || (state == ST_MEM);
  assign mem_we    = (state == ST_MEM) && wr_now;
  assign mem_addr  = (state == ST_FETCH) ? pc : data_addr;
  assign mem_wdata = data_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FETCH;
      pc       <= '0;
      acc      <= '0;
      qr       <= '0;
      sp       <= DS_BASE;
      rp       <= RS_BASE;
      ir       <= '0;
      lit_push <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: if (mem_ready) state <= ST_DECODE;

        ST_DECODE: begin
          ir <= mem_rdata;
          if (uses_mem) begin
            state <= ST_MEM;
          end else begin
            state <= ST_FETCH;
            case (op)
              OP_DROP: begin
                sp <= sp + ONE;
                pc <= pc_inc;
              end
              OP_SKZ:  pc <= (acc == '0) ? pc + TWO : pc_inc;
              OP_JMPQ: pc <= qr;
              OP_MOVQ: begin
                qr <= acc;
                pc <= pc_inc;
              end
              default: pc <= pc_inc;
            endcase
          end
        end

        ST_MEM: if (mem_ready) begin
          if (!wr_now) begin
            state <= ST_WB;
          end else begin
            state <= ST_FETCH;
            if (kind == K_CALL) begin
              rp <= rp_dn;
              pc <= ir;
            end else if (kind == K_HWLIT) begin
              sp       <= sp_dn;
              pc       <= pc + TWO;
              qr       <= pc + TWO;
              lit_push <= 1'b0;
            end else begin
              pc <= pc_inc;
              if (op == OP_PUSH) sp <= sp_dn;
            end
          end
        end

        ST_WB: begin
          state <= ST_FETCH;
          if (kind == K_HWLIT) begin
            acc      <= mem_rdata;
            lit_push <= 1'b1;
            state    <= ST_MEM;
          end else begin
            case (op)
              OP_RET: begin
                pc <= mem_rdata;
                rp <= rp + ONE;
              end
              OP_LDS_A: begin
                acc <= mem_rdata;
                sp  <= sp + ONE;
                pc  <= pc_inc;
              end
              OP_LDS_Q: begin
                qr <= mem_rdata;
                sp <= sp + ONE;
                pc <= pc_inc;
              end
              OP_ADD, OP_XOR, OP_AND: begin
                acc <= alu_y;
                sp  <= sp + ONE;
                pc  <= pc_inc;
              end
              OP_LDR_Q: begin
                qr <= mem_rdata;
                pc <= pc_inc;
              end
              OP_LDQ_A: begin
                acc <= mem_rdata;
                qr  <= qr + ONE;
                pc  <= pc_inc;
              end
              default: pc <= pc_inc;
            endcase
          end
        end

        default: state <= ST_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/zop_core_chk.sv
module zop_core_chk
  import zop_pkg::*;
#(
  parameter int           W       = 16,
  parameter logic [W-1:0] DS_BASE = 16'hE000,
  parameter logic [W-1:0] RS_BASE = 16'hF000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mem_valid,
  input logic         mem_ready,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic [W-1:0] mem_rdata,
  input state_e       state,
  input kind_e        kind,
  input prim_e        op,
  input logic [W-1:0] pc,
  input logic [W-1:0] sp,
  input logic [W-1:0] rp
);

  logic seen_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_accept <= 1'b0;
    else if (mem_valid && mem_ready) seen_accept <= 1'b1;
  end

  // R1
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_accept && mem_valid) |-> (mem_addr == '0 && !mem_we));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R3
  call_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEM && kind == K_CALL && mem_ready) |=>
      (rp == $past(mem_addr) && rp == $past(rp) - W'(1)));

  // R4
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB && kind == K_PRIM && op == OP_RET) |=>
      (pc == $past(mem_rdata) && rp == $past(rp) + W'(1)));

  // R6
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp <= DS_BASE) && (rp <= RS_BASE));

  // R11
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WB && kind != K_HWLIT) |=> (state == ST_FETCH));

endmodule

bind zop_core zop_core_chk #(.W(W), .DS_BASE(DS_BASE), .RS_BASE(RS_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata),
  .state     (state),
  .kind      (kind),
  .op        (op),
  .pc        (pc),
  .sp        (sp),
  .rp        (rp)
);

// File: tb/zop_core_bench.sv
`timescale 1ns/1ps
module zop_core_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        s_valid, s_ready, s_we, h_valid, h_ready, h_we;
  logic [15:0] s_addr, s_wdata, s_rdata, h_addr, h_wdata, h_rdata;
  logic [15:0] prog  [256];
  logic [15:0] mem_s [256];
  logic [15:0] mem_h [256];
  logic        s_done, h_done, pat, rnd_mode;
  logic [15:0] s_dn_addr, s_dn_data, h_dn_addr, h_dn_data;
  int          s_cnt, h_cnt, s_cyc, h_cyc;
  logic [7:0]  lf = 8'h5A;
  int          ncmp, nbad, pa, wd;

  zop_core #(.W(16), .DS_BASE(16'h00D0), .RS_BASE(16'h00E0),
             .HW_LIT(1'b0), .LIT_ADDR(16'h0010)) u_zop_core (
    .clk(clk), .rst_n(rst_n), .mem_valid(s_valid), .mem_ready(s_ready),
    .mem_we(s_we), .mem_addr(s_addr), .mem_wdata(s_wdata), .mem_rdata(s_rdata));

  zop_core #(.W(16), .DS_BASE(16'h00D0), .RS_BASE(16'h00E0),
             .HW_LIT(1'b1), .LIT_ADDR(16'h0010)) u_zop_core_hw (
    .clk(clk), .rst_n(rst_n), .mem_valid(h_valid), .mem_ready(h_ready),
    .mem_we(h_we), .mem_addr(h_addr), .mem_wdata(h_wdata), .mem_rdata(h_rdata));

  assign s_ready = pat & ~s_done;
  assign h_ready = pat & ~h_done;

  always @(negedge clk) begin
    lf  <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    pat <= rnd_mode ? (lf[0] | lf[1]) : 1'b1;
  end

  // memory model: one-cycle read latency, done marker = write to 0xF0..0xFF
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_s <= prog; mem_h <= prog;
      s_done <= 1'b0; h_done <= 1'b0;
      s_cnt <= 0; h_cnt <= 0; s_cyc <= 0; h_cyc <= 0;
    end else begin
      if (!s_done) s_cyc <= s_cyc + 1;
      if (!h_done) h_cyc <= h_cyc + 1;
      if (s_valid && s_ready) begin
        s_cnt <= s_cnt + 1;
        if (s_we) begin
          mem_s[s_addr[7:0]] <= s_wdata;
          if (s_addr >= 16'h00F0 && s_addr < 16'h0100) begin
            s_done <= 1'b1; s_dn_addr <= s_addr; s_dn_data <= s_wdata;
          end
        end else s_rdata <= mem_s[s_addr[7:0]];
      end
      if (h_valid && h_ready) begin
        h_cnt <= h_cnt + 1;
        if (h_we) begin
          mem_h[h_addr[7:0]] <= h_wdata;
          if (h_addr >= 16'h00F0 && h_addr < 16'h0100) begin
            h_done <= 1'b1; h_dn_addr <= h_addr; h_dn_data <= h_wdata;
          end
        end else h_rdata <= mem_h[h_addr[7:0]];
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int k = 0; k < 256; k++) prog[k] = 16'h000F;
    prog[0]  = 16'd32;                   // boot: call main at 32
    prog[16] = 16'd4; prog[17] = 16'd5;  // literal routine
    prog[18] = 16'd6; prog[19] = 16'd7; prog[20] = 16'd0;
    pa = 32;
  endtask

  task automatic emit(input logic [15:0] v);
    prog[pa] = v;
    pa++;
  endtask

  task automatic lit(input logic [15:0] v);
    emit(16'd16);
    emit(v);
  endtask

  task automatic tail();
    emit(16'd1); emit(16'd2); emit(16'd3);
  endtask

  task automatic run_case(input string tag, input logic [15:0] ea,
                          input logic [15:0] ed, input int es, input int eh);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "first request addr", {15'd0, s_valid, s_addr}, {15'd0, 1'b1, 16'h0000});
    chk("R1", "first request is read", {31'd0, h_we}, 32'd0);
    for (int i = 0; i < 1500 && !(s_done && h_done); i++) @(negedge clk);
    chk(tag, "soft done", {31'd0, s_done}, 32'd1);
    chk(tag, "hard done", {31'd0, h_done}, 32'd1);
    chk(tag, "soft result", {s_dn_addr, s_dn_data}, {ea, ed});
    chk(tag, "hard result", {h_dn_addr, h_dn_data}, {ea, ed});
    if (rnd_mode) chk("R2", "stalled run result", {16'd0, s_dn_data}, {16'd0, ed});
    chk("R11", "soft accesses", s_cnt, es);
    chk("R12", "hard accesses", h_cnt, eh);
    chk("R12", "shortcut faster", {31'd0, h_cyc < s_cyc}, 32'd1);
  endtask

  initial begin
    logic [15:0] vals [8];
    logic [15:0] x, y, r;
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
             16'h8000, 16'hFFFF, 16'h1234, 16'hA5A5};
    ncmp = 0; nbad = 0; rnd_mode = 1'b0;

    // R5: sweep of the three ALU ops over value pairs
    for (int o = 0; o < 3; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          x = vals[i]; y = vals[j];
          rnd_mode = 1'((i + j) % 2);
          clear_prog();
          lit(16'h00F0); lit(x); lit(y);
          emit(16'd1); emit(16'(8 + o)); emit(16'd6); tail();
          r = (o == 0) ? 16'(y + x) : (o == 1) ? (y ^ x) : (y & x);
          run_case("R5", 16'h00F0, r, 50, 23);
        end

    // R6 R7: literal push and store sequence
    for (int i = 0; i < 8; i++) begin
      rnd_mode = 1'(i % 2);
      clear_prog();
      lit(16'h00F0); lit(vals[i]); tail();
      run_case("R6 R7", 16'h00F0, vals[i], 32, 14);
    end

    // R10: drop and no-op
    for (int i = 0; i < 4; i++) begin
      rnd_mode = 1'(i % 2);
      clear_prog();
      lit(16'h00F0); lit(vals[i + 4]); lit(16'h0BAD);
      emit(16'd11); emit(16'd15); tail();
      run_case("R10", 16'h00F0, vals[i + 4], 46, 19);
    end

    // R8: skip when A is zero, else fall through
    for (int i = 0; i < 4; i++) begin
      logic [15:0] v;
      v = (i == 0) ? 16'h0000 : vals[i + 2];
      rnd_mode = 1'(i % 2);
      clear_prog();
      lit(16'h00F0); lit(16'h00F1); lit(v);
      emit(16'd1); emit(16'd12); emit(16'd9); emit(16'd6); tail();
      if (v == 16'h0000) run_case("R8", 16'h00F1, 16'h0000, 49, 22);
      else               run_case("R8", 16'h00F0, v ^ 16'h00F1, 51, 24);
    end

    // R9: jump to Q; fall-through path would store 0x0BAD
    for (int i = 0; i < 2; i++) begin
      rnd_mode = 1'(i);
      clear_prog();
      lit(16'h00F0); lit(vals[i + 6]); lit(16'h0060);
      emit(16'd2); emit(16'd13);
      emit(16'd11); lit(16'h0BAD); tail();
      pa = 16'h60; tail();
      run_case("R9", 16'h00F0, vals[i + 6], 47, 20);
    end

    // R9: A->Q then indexed load through Q
    for (int i = 0; i < 2; i++) begin
      rnd_mode = 1'(i);
      clear_prog();
      prog[16'h70] = vals[i + 3];
      lit(16'h00F0); lit(16'h0070);
      emit(16'd1); emit(16'd14); emit(16'd5); emit(16'd6); tail();
      run_case("R9", 16'h00F0, vals[i + 3], 39, 21);
    end

    // R3 R4: nested call into a routine at 0x40 that returns
    for (int i = 0; i < 3; i++) begin
      rnd_mode = 1'(i % 2);
      clear_prog();
      lit(16'h00F0); lit(vals[i + 1]); lit(vals[i + 5]);
      emit(16'h0040); tail();
      pa = 16'h40;
      lit(16'h0101); emit(16'd1); emit(16'd8); emit(16'd8); emit(16'd6); emit(16'd0);
      run_case("R3 R4", 16'h00F0,
               16'(vals[i + 1] + vals[i + 5] + 16'h0101), 68, 32);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd == 190000) begin
        ncmp++; nbad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
      end
    end
  end

endmodule